// File: doc/BRIEF.md
# Erasable PROM Mode Controller

This block is the control core of a byte-wide, one-time-writable read-only memory with a 19-bit address. It takes the active-low chip select and read enable, together with two digital flags that stand for analog levels: the programming supply being raised, and a high voltage on address line 9. From these it picks one of seven operating modes: standby, output off, read, program, program verify, write blocked and identifier readout. It then drives an 8-bit data bus through a registered value and a separate drive-enable. The pad that the drive-enable controls turns this into a tri-state bus.

The storage is a small parameterized array that comes out of reset fully erased, so every bit reads one. Programming ANDs the incoming byte into the stored byte, so a bit can only go from one to zero. A test-only erase input sets the whole array back to FFh on a single clock edge. Output timing is counted in clock edges. Read data appears only after the address, the chip select and the read enable have each been steady for their own number of edges. Until then the bus holds its last value, or shows X if a parameter asks for it. After a deselect the bus keeps driving for a set number of edges before it floats.

Top module: `eprom_mode_ctrl`

## Requirements
- R1: With ce_ni=0, oe_ni=0, vpp_hi_i=0 and no identifier match, the bus is driven (data_oe_o=1) with the stored byte at the addressed location.
- R2: With ce_ni=0, oe_ni=1 and vpp_hi_i=0, nothing is written and the bus floats (data_oe_o=0) once the turn-off delay of R9 has run out.
- R3: With ce_ni=1 and vpp_hi_i=0, the bus floats after the R9 delay whatever oe_ni is, and nothing is written. After reset data_oe_o=0 and data_o=00h.
- R4: With vpp_hi_i=1, ce_ni=0 and oe_ni=1, each clock edge replaces the addressed byte with (old AND data_i). Reset leaves every byte at FFh.
- R5: With vpp_hi_i=1, ce_ni=0 and oe_ni=0, the stored byte is driven as in R1.
- R6: With vpp_hi_i=1 and ce_ni=1, nothing is written and the bus floats after the R9 delay.
- R7: With a9_hv_i=1, ce_ni=0, oe_ni=0 and addr_i[18:1]=0, the bus shows 01h for addr_i[0]=0 and 9Bh for addr_i[0]=1, whatever vpp_hi_i is. Both codes have odd parity, with bit 7 as the parity bit. If any of addr_i[18:1] is set, the array is read instead.
- R8: An edge that samples ce_ni=oe_ni=0 loads new data only if the address has been equal for ACC_CYC edges, ce_ni low for CE_CYC edges and oe_ni low for OE_CYC edges, each count including that edge (defaults 4, 3, 2). Before that, data_o holds its value (INVALID_X=0).
- R9: After the first edge that samples ce_ni=1 or oe_ni=1, data_oe_o stays 1 with data_o unchanged for DF_CYC more edges (default 1), then goes to 0.
- R10: erase_i=1 at an edge sets every byte to FFh and takes precedence over a program write in the same edge.
- R11: Storage is indexed by addr_i[MEM_AW-1:0] (default 6 bits, 64 bytes). Higher address bits alias.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Read enable, active low |
| vpp_hi_i | input | 1 | Programming supply raised flag |
| a9_hv_i | input | 1 | High voltage on address line 9 flag |
| addr_i | input | 19 | Byte address |
| data_i | input | 8 | Byte to program, seen from the bus |
| erase_i | input | 1 | Test-only full-array erase |
| data_o | output | 8 | Registered bus data |
| data_oe_o | output | 1 | Bus drive enable |

## Verification
The bench first walks each row of the mode table with directed sequences. These tell apart reads of the array, the identifier codes with and without the programming supply, identifier requests blocked by a stray high address bit, and aliased addresses. A second program to a location that is already programmed shows that the AND merge differs from a plain overwrite. A write attempted in output-off and in blocked mode must leave the byte unchanged. Switching the address while the bus is enabled, and dropping the read enable alone, separate the address-age timing from the select-age timing and from the turn-off hold. A long pseudo-random phase then mixes all inputs, including erase during programming, against a cycle-by-cycle reference model.

// File: rtl/eprom_pkg.sv
package eprom_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_OUT_DIS,
    MODE_READ,
    MODE_PROGRAM,
    MODE_VERIFY,
    MODE_BLOCKED,
    MODE_IDENT
  } mode_e;

  localparam logic [BYTE_W-2:0] MFR_BITS = 7'h01;
  localparam logic [BYTE_W-2:0] DEV_BITS = 7'h1B;

  // msb makes the total count of ones odd
  function automatic logic [BYTE_W-1:0] odd_par(input logic [BYTE_W-2:0] b);
    return {~^b, b};
  endfunction
endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              vpp_hi_i,
  input  logic              a9_hv_i,
  input  logic [ADDR_W-1:1] addr_hi_i,
  output mode_e             mode_o
);
  logic id_ok;
  assign id_ok = a9_hv_i && (addr_hi_i == '0);

  always_comb begin
    if (ce_ni)      mode_o = vpp_hi_i ? MODE_BLOCKED : MODE_STANDBY;
    else if (oe_ni) mode_o = vpp_hi_i ? MODE_PROGRAM : MODE_OUT_DIS;
    else if (id_ok) mode_o = MODE_IDENT;
    else            mode_o = vpp_hi_i ? MODE_VERIFY : MODE_READ;
  end
endmodule

// File: rtl/eprom_array.sv
module eprom_array #(
  parameter int MEM_AW = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              erase_i,
  input  logic              wr_en_i,
  input  logic [MEM_AW-1:0] idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (erase_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (wr_en_i) begin
      mem_q[idx_i] <= mem_q[idx_i] & wdata_i;  // ones can only fall
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/eprom_access_timer.sv
module eprom_access_timer #(
  parameter int ADDR_W  = 19,
  parameter int ACC_CYC = 4,
  parameter int CE_CYC  = 3,
  parameter int OE_CYC  = 2,
  parameter int DF_CYC  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              active_o,
  output logic              valid_o,
  output logic              drive_o
);
  localparam int MAX0    = (ACC_CYC > CE_CYC) ? ACC_CYC : CE_CYC;
  localparam int MAX1    = (MAX0 > OE_CYC) ? MAX0 : OE_CYC;
  localparam int AGE_MAX = (MAX1 < 1) ? 1 : MAX1;
  localparam int AGE_W   = $clog2(AGE_MAX + 2);
  localparam int HOLD_W  = $clog2(DF_CYC + 2);

  logic [ADDR_W-1:0] addr_q;
  logic [AGE_W-1:0]  a_age_q, c_age_q, o_age_q;
  logic [AGE_W-1:0]  a_age_n, c_age_n, o_age_n;
  logic [HOLD_W-1:0] hold_q;
  logic              drive_q;

  function automatic logic [AGE_W-1:0] bump(input logic [AGE_W-1:0] v);
    return (v >= AGE_W'(AGE_MAX)) ? v : v + 1'b1;
  endfunction

  assign a_age_n = (addr_i != addr_q) ? AGE_W'(1) : bump(a_age_q);
  assign c_age_n = ce_ni ? '0 : bump(c_age_q);
  assign o_age_n = oe_ni ? '0 : bump(o_age_q);

  assign active_o = !ce_ni && !oe_ni;
  assign valid_o  = active_o
                 && (a_age_n >= AGE_W'(ACC_CYC))
                 && (c_age_n >= AGE_W'(CE_CYC))
                 && (o_age_n >= AGE_W'(OE_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      a_age_q <= '0;
      c_age_q <= '0;
      o_age_q <= '0;
    end else begin
      addr_q  <= addr_i;
      a_age_q <= a_age_n;
      c_age_q <= c_age_n;
      o_age_q <= o_age_n;
    end
  end

  // turn-off hold: keep driving DF_CYC edges after deselect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drive_q <= 1'b0;
      hold_q  <= '0;
    end else if (active_o) begin
      drive_q <= 1'b1;
      hold_q  <= HOLD_W'(DF_CYC);
    end else if (drive_q) begin
      if (hold_q == '0) drive_q <= 1'b0;
      else              hold_q  <= hold_q - 1'b1;
    end
  end

  assign drive_o = drive_q;
endmodule

// File: rtl/eprom_mode_ctrl.sv
module eprom_mode_ctrl
  import eprom_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int MEM_AW    = 6,
  parameter int ACC_CYC   = 4,
  parameter int CE_CYC    = 3,
  parameter int OE_CYC    = 2,
  parameter int DF_CYC    = 1,
  parameter bit INVALID_X = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              vpp_hi_i,
  input  logic              a9_hv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              erase_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              data_oe_o
);
  mode_e             cur_mode;
  logic              rd_active, rd_valid, drive;
  logic [BYTE_W-1:0] arr_rdata, id_byte, rd_byte, data_q;

  eprom_mode_dec #(.ADDR_W(ADDR_W)) u_dec (
    .ce_ni     (ce_ni),
    .oe_ni     (oe_ni),
    .vpp_hi_i  (vpp_hi_i),
    .a9_hv_i   (a9_hv_i),
    .addr_hi_i (addr_i[ADDR_W-1:1]),
    .mode_o    (cur_mode)
  );

  eprom_array #(.MEM_AW(MEM_AW), .DATA_W(BYTE_W)) u_arr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .erase_i (erase_i),
    .wr_en_i (cur_mode == MODE_PROGRAM),
    .idx_i   (addr_i[MEM_AW-1:0]),
    .wdata_i (data_i),
    .rdata_o (arr_rdata)
  );

  eprom_access_timer #(
    .ADDR_W(ADDR_W), .ACC_CYC(ACC_CYC), .CE_CYC(CE_CYC),
    .OE_CYC(OE_CYC), .DF_CYC(DF_CYC)
  ) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_ni    (ce_ni),
    .oe_ni    (oe_ni),
    .addr_i   (addr_i),
    .active_o (rd_active),
    .valid_o  (rd_valid),
    .drive_o  (drive)
  );

  assign id_byte = addr_i[0] ? odd_par(DEV_BITS) : odd_par(MFR_BITS);
  assign rd_byte = (cur_mode == MODE_IDENT) ? id_byte : arr_rdata;

  generate
    if (INVALID_X) begin : g_xfill
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        data_q <= '0;
        else if (rd_active) data_q <= rd_valid ? rd_byte : 'x;
      end
    end else begin : g_hold
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                   data_q <= '0;
        else if (rd_active && rd_valid) data_q <= rd_byte;
      end
    end
  endgenerate

  assign data_o    = data_q;
  assign data_oe_o = drive;
endmodule

// File: rtl/eprom_mode_ctrl_chk.sv
module eprom_mode_ctrl_chk
  import eprom_pkg::*;
#(
  parameter int DF_CYC    = 1,
  parameter bit INVALID_X = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic [BYTE_W-1:0] data_o,
  input logic              data_oe_o,
  input logic              rd_active,
  input logic              rd_valid,
  input mode_e             cur_mode
);
  int   idle_q;
  logic up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= 0;
      up_q   <= 1'b0;
    end else begin
      up_q   <= 1'b1;
      idle_q <= (ce_ni || oe_ni) ? ((idle_q < DF_CYC + 4) ? idle_q + 1 : idle_q) : 0;
    end
  end

  // R9 / R2 / R3 / R6: bus released once the hold window has passed
  p_float_after_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_q > DF_CYC) |-> !data_oe_o);

  // R1: driving only starts from a sampled select
  p_drive_needs_select_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_oe_o) |-> $past(!ce_ni && !oe_ni));

  // R7: loaded identifier byte has odd parity
  p_ident_odd_parity_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && $past(rd_valid && cur_mode == MODE_IDENT)) |-> (^data_o));

  // R5 / R1: a loaded byte is driven on the next cycle
  p_loaded_is_driven_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && $past(rd_valid)) |-> data_oe_o);

  generate
    if (!INVALID_X) begin : g_hold_chk
      // R8: no update while access time has not elapsed
      p_hold_until_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (up_q && $past(rd_active && !rd_valid)) |-> $stable(data_o));
    end
  endgenerate
endmodule

bind eprom_mode_ctrl eprom_mode_ctrl_chk #(.DF_CYC(DF_CYC), .INVALID_X(INVALID_X)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ce_ni     (ce_ni),
  .oe_ni     (oe_ni),
  .data_o    (data_o),
  .data_oe_o (data_oe_o),
  .rd_active (rd_active),
  .rd_valid  (rd_valid),
  .cur_mode  (cur_mode)
);

// File: tb/eprom_mode_ctrl_tb_top.sv
module eprom_mode_ctrl_tb_top;
  localparam int AW  = 19;
  localparam int MAW = 6;
  localparam int ACC = 4;
  localparam int CEC = 3;
  localparam int OEC = 2;
  localparam int DF  = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce = 1'b1, oe = 1'b1, vpp = 1'b0, a9 = 1'b0, er = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    dout;
  logic          doe;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  eprom_mode_ctrl #(
    .ADDR_W(AW), .MEM_AW(MAW), .ACC_CYC(ACC), .CE_CYC(CEC),
    .OE_CYC(OEC), .DF_CYC(DF), .INVALID_X(1'b0)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce), .oe_ni(oe), .vpp_hi_i(vpp),
    .a9_hv_i(a9), .addr_i(addr), .data_i(din), .erase_i(er),
    .data_o(dout), .data_oe_o(doe)
  );

  // reference model
  logic [7:0]    m_mem [64];
  logic [AW-1:0] m_addr;
  int            m_a, m_c, m_o, m_hold;
  bit            m_drv;
  logic [7:0]    m_dq;
  string         m_tag;

  function automatic int sat(input int v);
    return (v < 1000) ? v + 1 : v;
  endfunction

  function automatic bit is_ident(input logic a9v, input logic [AW-1:0] a);
    return a9v && (a[AW-1:1] == 0);
  endfunction

  function automatic string float_tag(input logic c, input logic v);
    if (c) return v ? "R6" : "R3";
    return v ? "R4" : "R2";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) m_mem[i] = 8'hFF;
      m_addr = '0; m_a = 0; m_c = 0; m_o = 0; m_hold = 0;
      m_drv = 1'b0; m_dq = 8'h00; m_tag = "R3";
    end else begin
      m_a = (addr != m_addr) ? 1 : sat(m_a);
      m_addr = addr;
      m_c = ce ? 0 : sat(m_c);
      m_o = oe ? 0 : sat(m_o);
      if (!ce && !oe) begin
        m_drv = 1'b1;
        m_hold = DF;
        if (m_a >= ACC && m_c >= CEC && m_o >= OEC) begin
          if (is_ident(a9, addr)) begin
            m_dq = addr[0] ? 8'h9B : 8'h01;
            m_tag = "R7";
          end else begin
            m_dq = m_mem[addr[MAW-1:0]];
            m_tag = vpp ? "R5" : "R1";
          end
        end else m_tag = "R8";
      end else if (m_drv) begin
        if (m_hold == 0) begin
          m_drv = 1'b0;
          m_tag = float_tag(ce, vpp);
        end else begin
          m_hold = m_hold - 1;
          m_tag = "R9";
        end
      end else m_tag = float_tag(ce, vpp);
      if (er) begin
        for (int i = 0; i < 64; i++) m_mem[i] = 8'hFF;
      end else if (vpp && !ce && oe) begin
        m_mem[addr[MAW-1:0]] = m_mem[addr[MAW-1:0]] & din;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      n_vec++;
      if (doe !== m_drv || (m_drv && dout !== m_dq)) begin
        n_bad++;
        $display("FAIL %s cycle compare: oe=%0b data=%02h expected oe=%0b data=%02h",
                 m_tag, doe, dout, m_drv, m_dq);
      end
    end
  end

  task automatic chk(input string tag, input logic exp_oe, input logic [7:0] exp_d);
    n_vec++;
    if (doe !== exp_oe || (exp_oe && dout !== exp_d)) begin
      n_bad++;
      $display("FAIL %s: oe=%0b data=%02h expected oe=%0b data=%02h",
               tag, doe, dout, exp_oe, exp_d);
    end
  endtask

  task automatic apply(input logic c, input logic o, input logic v, input logic a,
                       input logic [AW-1:0] ad, input logic [7:0] d, input logic e,
                       input int n);
    ce = c; oe = o; vpp = v; a9 = a; addr = ad; din = d; er = e;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    chk("R3 reset", 1'b0, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 after reset", 1'b0, 8'h00);

    // erased read
    apply(0, 0, 0, 0, 19'd5, 8'h00, 0, 6);
    chk("R4 erased byte", 1'b1, 8'hFF);
    // program twice: AND merge
    apply(0, 1, 1, 0, 19'd5, 8'hA5, 0, 3);
    apply(0, 1, 1, 0, 19'd5, 8'h0F, 0, 2);
    chk("R4 program floats bus", 1'b0, 8'h00);
    apply(0, 0, 1, 0, 19'd5, 8'h00, 0, 5);
    chk("R5 verify merged byte", 1'b1, 8'h05);
    // R9: one extra driven edge after oe goes high
    apply(0, 1, 0, 0, 19'd5, 8'h00, 0, 1);
    chk("R9 hold after deselect", 1'b1, 8'h05);
    apply(0, 1, 0, 0, 19'd5, 8'h00, 0, 1);
    chk("R9 floated after hold", 1'b0, 8'h00);
    // blocked write
    apply(1, 1, 1, 0, 19'd5, 8'h00, 0, 3);
    chk("R6 blocked floats", 1'b0, 8'h00);
    apply(0, 0, 0, 0, 19'd5, 8'h00, 0, 5);
    chk("R6 byte unchanged", 1'b1, 8'h05);
    // output off, no write
    apply(0, 1, 0, 0, 19'd5, 8'h00, 0, 3);
    chk("R2 output off floats", 1'b0, 8'h00);
    apply(0, 0, 0, 0, 19'd5, 8'h00, 0, 5);
    chk("R2 byte unchanged", 1'b1, 8'h05);
    // standby with read enable low
    apply(1, 0, 0, 0, 19'd5, 8'h00, 0, 3);
    chk("R3 standby floats", 1'b0, 8'h00);
    // identifier codes
    apply(0, 0, 0, 1, 19'd0, 8'h00, 0, 5);
    chk("R7 maker code", 1'b1, 8'h01);
    apply(0, 0, 0, 1, 19'd1, 8'h00, 0, 5);
    chk("R7 device code", 1'b1, 8'h9B);
    apply(0, 0, 1, 1, 19'd1, 8'h00, 0, 5);
    chk("R7 device code with supply", 1'b1, 8'h9B);
    apply(0, 0, 0, 1, 19'h40001, 8'h00, 0, 5);
    chk("R7 high bit blocks ident", 1'b1, 8'hFF);
    apply(0, 0, 0, 0, 19'h40005, 8'h00, 0, 5);
    chk("R11 aliased address", 1'b1, 8'h05);
    // address-age timing
    apply(0, 1, 1, 0, 19'd6, 8'h3C, 0, 2);
    apply(0, 0, 0, 0, 19'd5, 8'h00, 0, 5);
    chk("R1 read before switch", 1'b1, 8'h05);
    apply(0, 0, 0, 0, 19'd6, 8'h00, 0, 1);
    chk("R8 edge 1 holds", 1'b1, 8'h05);
    apply(0, 0, 0, 0, 19'd6, 8'h00, 0, 2);
    chk("R8 edge 3 holds", 1'b1, 8'h05);
    apply(0, 0, 0, 0, 19'd6, 8'h00, 0, 1);
    chk("R8 edge 4 loads", 1'b1, 8'h3C);
    // erase beats program
    apply(0, 1, 1, 0, 19'd5, 8'h00, 1, 1);
    apply(0, 0, 0, 0, 19'd5, 8'h00, 0, 5);
    chk("R10 erased over program", 1'b1, 8'hFF);
    apply(0, 0, 0, 0, 19'd6, 8'h00, 0, 5);
    chk("R10 other byte erased", 1'b1, 8'hFF);

    // pseudo-random phase, checked by the model each cycle
    lfsr = 16'hACE1;
    for (int k = 0; k < 600; k++) begin
      logic [AW-1:0] ad;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[10:8])
        3'd0: ad = 19'd0;
        3'd1: ad = 19'd1;
        3'd2: ad = 19'd2;
        3'd3: ad = 19'd5;
        3'd4: ad = 19'h40001;
        default: ad = 19'd6;
      endcase
      apply(lfsr[0] & lfsr[1], lfsr[2] & lfsr[11], lfsr[3], lfsr[4] & lfsr[5],
            ad, lfsr[15:8], &lfsr[7:3], 1 + int'(lfsr[13:12]));
    end

    summary();
    $finish;
  end
endmodule